// File: doc/BRIEF.md
# Fixed-Point Logical Execution Unit

This unit is the logical slice of a 64-bit integer pipeline. Each cycle it takes one decoded 32-bit instruction word, two 64-bit source operands and the current summary-overflow bit. It produces the destination value together with a valid flag. It also produces the 4-bit condition field 0 and a strobe that says whether that field is to be written. The operations are bitwise logic with a register or an immediate operand, sign extension from a byte, halfword or word, and a count of leading zeros over a doubleword or a word.

Bit numbering follows the instruction set convention: bit 0 is the most significant bit. In the 32-bit word, bit 0 is `instr_i[31]` and bit 31 is `instr_i[0]`. In a 64-bit operand, bit 0 is `[63]` and bit 63 is `[0]`. All outputs are registered, so a result appears one clock after its instruction is presented. Register-file access, trapping and carry/overflow generation belong to other parts of the pipeline.

Top module: `fx_logic_unit`

## Requirements
- R1: The primary opcode sits at instruction bits 0:5 and the 16-bit immediate at bits 16:31. Opcode 24 ORs RS with the zero-extended immediate and 25 ORs RS with the immediate placed at operand bits 32:47, zero elsewhere. Opcode 26 XORs with the low immediate and 27 XORs with the shifted one. Opcode 28 ANDs with the low immediate and 29 ANDs with the shifted one.
- R2: Primary opcode 31 with the 10-bit extended opcode at instruction bits 21:30 selects a register form. The register forms are 28 RS&RB, 444 RS|RB, 284 ~(RS^RB), 60 RS&~RB and 412 RS|~RB.
- R3: Extended opcode 954 copies RS bits 56:63 and fills bits 0:55 with RS bit 56. Extended opcode 922 keeps bits 48:63 and fills from bit 48. Extended opcode 986 keeps bits 32:63 and fills from bit 32.
- R4: Extended opcode 58 returns the number of consecutive zeros of RS counted from bit 0, in the range 0 to 64. A zero operand gives 64.
- R5: Extended opcode 26 counts leading zeros of RS bits 32:63 only, returning 0 to 32. The upper half of RS has no effect.
- R6: The condition field is `cr0_o = {LT,GT,EQ,SO}` (bit 3 LT, bit 0 SO). LT, GT and EQ come from a signed comparison of the 64-bit result with zero, exactly one of them set. SO copies `so_i` from the issuing cycle. The field reads zero whenever it is not written.
- R7: Opcodes 28 and 29 always assert `cr0_we_o`. Opcodes 24 to 27 never assert it.
- R8: Every recognised opcode-31 form asserts `cr0_we_o` exactly when the record bit (instruction bit 31, `instr_i[0]`) is 1.
- R9: A leading-zero count with the record bit set writes a condition field whose LT bit is 0.
- R10: Any other primary or extended opcode yields `ra_valid_o`=0, `cr0_we_o`=0 and a zero `ra_o`.
- R11: Outputs follow their instruction by exactly one clock. A synchronous active-high reset clears the valid flags, the result and the condition field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Decoded instruction word |
| rs_i | input | 64 | First source operand |
| rb_i | input | 64 | Second source operand |
| so_i | input | 1 | Current summary-overflow bit |
| ra_o | output | 64 | Destination value |
| ra_valid_o | output | 1 | Destination value is valid |
| cr0_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr0_we_o | output | 1 | Condition field write strobe |

## Verification
The hardest cases to reach are the ends of the leading-zero ranges. A zero operand, an operand with only its last bit set, and a word count whose upper half is full of ones while the lower half is zero almost never arise from uniformly random operands. The stimulus therefore runs a directed set of these operands first. It then draws operands from a mix of zeros, single walking ones, sign-boundary patterns and random values. Each opcode is sent with the record bit both set and clear, and with the summary-overflow input toggled.

// File: rtl/fx_logic_unit.sv
module fx_logic_unit #(
  parameter int XLEN = 64,
  parameter int ILEN = 32,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rb_i,
  input  logic            so_i,
  output logic [XLEN-1:0] ra_o,
  output logic            ra_valid_o,
  output logic [3:0]      cr0_o,
  output logic            cr0_we_o
);
  localparam int HALF = XLEN / 2;
  localparam int CNTW = $clog2(XLEN) + 1;

  logic [5:0] prim;
  logic [9:0] xop;
  logic       rc;
  logic [IMMW-1:0] imm;
  logic [XLEN-1:0] imm_lo, imm_hi;
  logic [XLEN-1:0] res;
  logic ok, wr, is_cnt;
  logic [3:0] cr_n;
  logic unused_fields;

  assign prim   = instr_i[ILEN-1 -: 6];
  assign xop    = instr_i[10:1];
  assign rc     = instr_i[0];
  assign imm    = instr_i[IMMW-1:0];
  assign imm_lo = {{(XLEN-IMMW){1'b0}}, imm};
  assign imm_hi = {{(XLEN-HALF-IMMW){1'b0}}, imm, {(HALF-IMMW){1'b0}}};
  assign unused_fields = ^instr_i[25:16];

  function automatic logic [CNTW-1:0] lz_dw(input logic [XLEN-1:0] v);
    lz_dw = CNTW'(XLEN);
    for (int i = 0; i < XLEN; i++)
      if (v[i]) lz_dw = CNTW'(XLEN - 1 - i);
  endfunction

  function automatic logic [CNTW-1:0] lz_w(input logic [HALF-1:0] v);
    lz_w = CNTW'(HALF);
    for (int i = 0; i < HALF; i++)
      if (v[i]) lz_w = CNTW'(HALF - 1 - i);
  endfunction

  always_comb begin
    ok = 1'b1;
    wr = 1'b0;
    is_cnt = 1'b0;
    res = '0;
    case (prim)
      6'd24: res = rs_i | imm_lo;
      6'd25: res = rs_i | imm_hi;
      6'd26: res = rs_i ^ imm_lo;
      6'd27: res = rs_i ^ imm_hi;
      6'd28: begin res = rs_i & imm_lo; wr = 1'b1; end
      6'd29: begin res = rs_i & imm_hi; wr = 1'b1; end
      6'd31: begin
        wr = rc;
        case (xop)
          10'd28:  res = rs_i & rb_i;
          10'd444: res = rs_i | rb_i;
          10'd284: res = ~(rs_i ^ rb_i);
          10'd60:  res = rs_i & ~rb_i;
          10'd412: res = rs_i | ~rb_i;
          10'd954: res = {{(XLEN-8){rs_i[7]}}, rs_i[7:0]};
          10'd922: res = {{(XLEN-16){rs_i[15]}}, rs_i[15:0]};
          10'd986: res = {{(XLEN-HALF){rs_i[HALF-1]}}, rs_i[HALF-1:0]};
          10'd58:  begin res = XLEN'(lz_dw(rs_i)); is_cnt = 1'b1; end
          10'd26:  begin res = XLEN'(lz_w(rs_i[HALF-1:0])); is_cnt = 1'b1; end
          default: begin ok = 1'b0; wr = 1'b0; end
        endcase
      end
      default: ok = 1'b0;
    endcase
  end

  assign cr_n = {res[XLEN-1] & ~is_cnt,
                 ~res[XLEN-1] & (|res),
                 ~(|res),
                 so_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_o       <= '0;
      ra_valid_o <= 1'b0;
      cr0_o      <= '0;
      cr0_we_o   <= 1'b0;
    end else begin
      ra_o       <= ok ? res : '0;
      ra_valid_o <= ok;
      cr0_we_o   <= ok & wr;
      cr0_o      <= (ok & wr) ? cr_n : 4'b0;
    end
  end

  p_cr_one_hot_r6: assert property (@(posedge clk) disable iff (rst)
    cr0_we_o |-> $onehot(cr0_o[3:1]));

  p_cr_eq_matches_r6: assert property (@(posedge clk) disable iff (rst)
    cr0_we_o |-> (cr0_o[1] == (ra_o == '0)) && (cr0_o[3] == ra_o[XLEN-1]));

  p_cr_so_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (!rst && (prim == 6'd28 || prim == 6'd29)) |=> cr0_o[0] == $past(so_i));

  p_and_imm_writes_r7: assert property (@(posedge clk) disable iff (rst)
    (prim == 6'd28 || prim == 6'd29) |=> cr0_we_o && ra_valid_o);

  p_or_xor_imm_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (prim >= 6'd24 && prim <= 6'd27) |=> !cr0_we_o && ra_valid_o);

  p_rec_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (prim == 6'd31 && !rc) |=> !cr0_we_o);

  p_count_lt_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (prim == 6'd31 && (xop == 10'd58 || xop == 10'd26)) |=>
      !cr0_o[3] && ra_o <= XLEN);

  p_invalid_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !ra_valid_o |-> !cr0_we_o && ra_o == '0 && cr0_o == 4'b0);
endmodule

// File: tb/fx_logic_unit_tb.sv
module fx_logic_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [63:0] rs = '0, rb = '0;
  logic        so = 1'b0;
  logic [63:0] ra;
  logic        ra_valid, cr_we;
  logic [3:0]  cr;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [69:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  fx_logic_unit u_dut (
    .clk(clk), .rst(rst), .instr_i(instr), .rs_i(rs), .rb_i(rb), .so_i(so),
    .ra_o(ra), .ra_valid_o(ra_valid), .cr0_o(cr), .cr0_we_o(cr_we)
  );

  function automatic logic [31:0] d_form(input int po, input logic [15:0] imm);
    return {6'(po), 5'd3, 5'd4, imm};
  endfunction

  function automatic logic [31:0] x_form(input int xo, input bit rec);
    return {6'd31, 5'd3, 5'd4, 5'd5, 10'(xo), rec};
  endfunction

  task automatic model(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                       input logic s, output logic [69:0] e, output string tag);
    int po, xo, n;
    logic v, w;
    logic [63:0] r, k;
    logic [3:0] c;
    po = int'(ins[31:26]);
    xo = int'(ins[10:1]);
    k  = 64'(ins[15:0]);
    v = 1; w = 0; r = '0; tag = "R10";
    if (po == 24) begin r = a | k; tag = "R1/R7"; end
    else if (po == 25) begin r = a | (k << 16); tag = "R1/R7"; end
    else if (po == 26) begin r = a ^ k; tag = "R1/R7"; end
    else if (po == 27) begin r = a ^ (k << 16); tag = "R1/R7"; end
    else if (po == 28) begin r = a & k; w = 1; tag = "R1/R7"; end
    else if (po == 29) begin r = a & (k << 16); w = 1; tag = "R1/R7"; end
    else if (po == 31) begin
      w = ins[0];
      case (xo)
        28:  begin r = a & b; tag = "R2/R8"; end
        444: begin r = a | b; tag = "R2/R8"; end
        284: begin r = ~(a ^ b); tag = "R2/R8"; end
        60:  begin r = a & ~b; tag = "R2/R8"; end
        412: begin r = a | ~b; tag = "R2/R8"; end
        954: begin r = a; for (int i = 8; i < 64; i++) r[i] = a[7]; tag = "R3/R8"; end
        922: begin r = a; for (int i = 16; i < 64; i++) r[i] = a[15]; tag = "R3/R8"; end
        986: begin r = a; for (int i = 32; i < 64; i++) r[i] = a[31]; tag = "R3/R8"; end
        58: begin
          n = 0;
          while (n < 64 && a[63-n] == 1'b0) n++;
          r = 64'(n); tag = "R4/R9";
        end
        26: begin
          n = 0;
          while (n < 32 && a[31-n] == 1'b0) n++;
          r = 64'(n); tag = "R5/R9";
        end
        default: begin v = 0; w = 0; end
      endcase
    end else begin
      v = 0;
    end
    if (!v) r = '0;
    c = 4'b0;
    if (v && w) c = {$signed(r) < 0, $signed(r) > 0, r == 0, s};
    e = {v, w, c, r};
  endtask

  task automatic check(input bit ok, input string what, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_pending();
    logic [69:0] e;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    check(ra_valid === e[69], "valid", {t, " R10 R11"}, 64'(ra_valid), 64'(e[69]));
    check(cr_we === e[68], "cr_we", {t, " R7 R8"}, 64'(cr_we), 64'(e[68]));
    check(cr === e[67:64], "cr", {t, " R6"}, 64'(cr), 64'(e[67:64]));
    check(ra === e[63:0], "result", t, ra, e[63:0]);
  endtask

  task automatic step(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                      input logic s);
    logic [69:0] e;
    string t;
    @(negedge clk);
    compare_pending();
    instr = ins; rs = a; rb = b; so = s;
    model(ins, a, b, s, e, t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  function automatic logic [63:0] pick_operand(input int sel);
    logic [63:0] v;
    v = {$urandom(), $urandom()};
    case (sel % 6)
      0: return '0;
      1: return 64'(1) << ($urandom() % 64);
      2: return {1'b1, 63'b0};
      3: return v >> ($urandom() % 64);
      4: return {32'hFFFF_FFFF, 32'b0} | (64'(1) << ($urandom() % 32));
      default: return v;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int xops[10];
    int pos[7];
    xops = '{28, 444, 284, 60, 412, 954, 922, 986, 58, 26};
    pos  = '{24, 25, 26, 27, 28, 29, 31};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check(ra_valid === 1'b0 && cr_we === 1'b0, "reset flags", "R11", 64'({ra_valid, cr_we}), 64'(0));
    check(ra === '0 && cr === 4'b0, "reset data", "R11", ra, 64'(0));
    rst = 1'b0;

    // R1 / R7 immediate forms
    step(d_form(24, 16'h00F0), 64'h8000_0000_0000_000F, '0, 1'b0);
    step(d_form(25, 16'hABCD), 64'h0000_0000_0000_1111, '0, 1'b1);
    step(d_form(26, 16'hFFFF), 64'h1234_5678_9ABC_DEF0, '0, 1'b0);
    step(d_form(27, 16'hFFFF), 64'h1234_5678_9ABC_DEF0, '0, 1'b0);
    step(d_form(28, 16'h8001), 64'hFFFF_FFFF_FFFF_FFFF, '0, 1'b1);
    step(d_form(28, 16'h0000), 64'hFFFF_FFFF_FFFF_FFFF, '0, 1'b0);
    step(d_form(29, 16'h8000), 64'hFFFF_FFFF_FFFF_FFFF, '0, 1'b1);
    step(d_form(24, 16'h0000), '0, '0, 1'b0);
    // R2 / R8 register forms, both record settings
    for (int i = 0; i < 5; i++) begin
      step(x_form(xops[i], 1'b0), 64'hF0F0_0000_FFFF_1234, 64'hFF00_FF00_0F0F_8888, 1'b1);
      step(x_form(xops[i], 1'b1), 64'hF0F0_0000_FFFF_1234, 64'hFF00_FF00_0F0F_8888, 1'b1);
    end
    step(x_form(444, 1'b1), '0, '0, 1'b0);
    // R3 sign extension at both signs
    step(x_form(954, 1'b1), 64'h1234_5678_9ABC_DE80, '0, 1'b0);
    step(x_form(954, 1'b1), 64'hFFFF_FFFF_FFFF_FF7F, '0, 1'b0);
    step(x_form(922, 1'b0), 64'h0000_0000_0000_8000, '0, 1'b0);
    step(x_form(922, 1'b1), 64'hFFFF_0000_0000_7FFF, '0, 1'b1);
    step(x_form(986, 1'b1), 64'h0000_0000_8000_0000, '0, 1'b0);
    step(x_form(986, 1'b1), 64'hFFFF_FFFF_7FFF_FFFF, '0, 1'b0);
    // R4 / R5 / R9 count boundaries
    step(x_form(58, 1'b1), '0, '0, 1'b1);
    step(x_form(58, 1'b1), 64'h1, '0, 1'b0);
    step(x_form(58, 1'b1), 64'h8000_0000_0000_0000, '0, 1'b0);
    step(x_form(58, 1'b0), 64'h0000_0001_0000_0000, '0, 1'b0);
    step(x_form(26, 1'b1), 64'hFFFF_FFFF_0000_0000, '0, 1'b1);
    step(x_form(26, 1'b1), 64'hFFFF_FFFF_8000_0000, '0, 1'b0);
    step(x_form(26, 1'b1), 64'h0000_0000_0000_0001, '0, 1'b0);
    step(x_form(26, 1'b0), 64'h0000_0000_0001_0000, '0, 1'b0);
    // R10 unrecognised opcodes
    step(d_form(0, 16'hFFFF), 64'hFFFF, 64'hFFFF, 1'b1);
    step(d_form(30, 16'h1234), 64'hFFFF, 64'hFFFF, 1'b1);
    step(x_form(316, 1'b1), 64'hFFFF, 64'h1, 1'b1);
    step(x_form(0, 1'b1), 64'hFFFF, 64'h1, 1'b1);

    // mixed stimulus
    for (int n = 0; n < 4000; n++) begin
      int p;
      logic [31:0] ins;
      p = pos[$urandom() % 7];
      if ($urandom() % 20 == 0) ins = {6'($urandom()), 26'($urandom())};
      else if (p == 31) ins = x_form(xops[$urandom() % 10], 1'($urandom()));
      else ins = d_form(p, 16'($urandom()));
      step(ins, pick_operand(int'($urandom() % 6)), pick_operand(int'($urandom() % 6)),
           1'($urandom()));
    end

    // R11: reset mid-stream clears the registered outputs
    step(d_form(28, 16'hFFFF), 64'hFFFF, '0, 1'b1);
    @(negedge clk);
    compare_pending();
    rst = 1'b1;
    @(negedge clk);
    check(ra_valid === 1'b0 && cr_we === 1'b0 && ra === '0 && cr === 4'b0,
          "mid reset", "R11", ra, 64'(0));
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule